// File: doc/BRIEF.md
# Packet Halfword Receive Channel

This block takes 16-bit halfwords from a parallel port and turns them into packets stored in 36-bit word memory. A handshake block outside it raises a pending flag for each halfword. The channel answers with a one-cycle accept strobe whenever it consumes one.

While idle, the channel reads the pending halfword as the length of the next packet. It compares that length with the capacity of the buffer at the head of a free-buffer queue. If the buffer is large enough, it claims the buffer and writes the buffer's header. It then packs the following data halfwords two per memory word. When the last halfword arrives, the packet's header address is pushed onto a done queue.

A packet that is too long for the offered buffer is dropped at its length halfword. This lets the link find its framing again after a restart. An empty free queue stops the channel by clearing its receive enable. Software raises the enable again with a wake pulse.

Top module: `rxc_top`

## Requirements
- R1: While idle with the receive enable clear, a pending halfword is not accepted, and nothing is popped, written or pushed.
- R2: While idle and enabled, a pending length of zero is accepted and has no other effect: no pop, no write, and the channel stays idle.
- R3: While idle and enabled, a nonzero length with the free queue empty is not accepted. From the next cycle the enable reads 0 and the channel stays idle.
- R4: While idle and enabled, a length larger than the head buffer's capacity is accepted without a pop or a write, and the channel stays idle. A length equal to the capacity is not dropped.
- R5: A length that fits claims the buffer in the same cycle, and that cycle has a pop and a memory write at the buffer address. The header word written holds the length in bits 33:18, with all other bits zero.
- R6: Once a buffer is claimed, the next `length` pending halfwords are each accepted in their own cycle, whatever the enable. After the last of them, the next halfword is again treated as a length.
- R7: Data halfword k (counted from 0) of a packet at buffer address B goes into word B+1+k/2. An even-k halfword is held until halfword k+1 arrives. Then both are written in one write: the first in bits 35:20, the second in bits 19:4, with bits 3:0 zero.
- R8: If a packet has an odd length, its last halfword is written alone in the same cycle it arrives, in bits 35:20, with all other bits zero. The last halfword of every packet is accepted in a cycle that also pushes the buffer address onto the done queue.
- R9: Reset clears the enable. A one-cycle wake pulse sets it from the next cycle on. If a wake pulse and an empty-queue stop fall in the same cycle, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Pulse that sets the receive enable |
| pend_i | input | 1 | A halfword is waiting at the port |
| hw_i | input | 16 | The waiting halfword |
| acc_o | output | 1 | The halfword is consumed at this edge |
| en_o | output | 1 | Receive enable |
| fq_valid_i | input | 1 | Free queue holds a buffer |
| fq_addr_i | input | AW | Header address of the head buffer |
| fq_cap_i | input | 16 | Capacity of the head buffer in halfwords |
| fq_pop_o | output | 1 | Remove the head buffer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Word address of the write |
| mem_wdata_o | output | 36 | Word written |
| dq_push_o | output | 1 | Push a finished packet |
| dq_addr_o | output | AW | Header address of the finished packet |

## Verification
The hardest case to reach from the ports is a length that is refused while a usable buffer sits in the free queue. It has to be told apart both from a clean claim and from an empty-queue stop. The stimulus queues a buffer with a random capacity, then offers a length slightly above that capacity before the real packet. It then checks that the same buffer is still the one claimed afterwards. A length exactly equal to the capacity, odd and even packet lengths, and a wake pulse after a stop are driven as directed cases.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 36;
  localparam int UP_LSB = 20;
  localparam int LO_LSB = 4;
  localparam int LEN_LSB = 18;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t hdr_word(input half_t len);
    word_t w;
    w = '0;
    w[LEN_LSB +: HALF_W] = len;
    return w;
  endfunction

  function automatic word_t pair_word(input half_t hi, input half_t lo);
    word_t w;
    w = '0;
    w[UP_LSB +: HALF_W] = hi;
    w[LO_LSB +: HALF_W] = lo;
    return w;
  endfunction

  function automatic word_t solo_word(input half_t hi);
    return pair_word(hi, '0);
  endfunction
endpackage

// File: rtl/rxc_enable.sv
module rxc_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic stop_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (stop_i) en_q <= 1'b0;
    else if (wake_i) en_q <= 1'b1;
  end

  assign en_o = en_q;
endmodule

// File: rtl/rxc_frame_ctl.sv
module rxc_frame_ctl
  import rxc_pkg::*;
(
  input  logic  busy_i,
  input  logic  en_i,
  input  logic  pend_i,
  input  half_t len_i,
  input  logic  fq_valid_i,
  input  half_t fq_cap_i,
  output logic  ev_zero_o,
  output logic  ev_stall_o,
  output logic  ev_big_o,
  output logic  ev_claim_o,
  output logic  ev_data_o,
  output logic  acc_o
);
  logic look;
  logic nonzero;

  assign look    = pend_i && !busy_i && en_i;
  assign nonzero = (len_i != '0);

  assign ev_zero_o  = look && !nonzero;
  assign ev_stall_o = look && nonzero && !fq_valid_i;
  assign ev_big_o   = look && nonzero && fq_valid_i && (len_i > fq_cap_i);
  assign ev_claim_o = look && nonzero && fq_valid_i && (len_i <= fq_cap_i);
  assign ev_data_o  = pend_i && busy_i;

  assign acc_o = ev_zero_o || ev_big_o || ev_claim_o || ev_data_o;
endmodule

// File: rtl/rxc_packer.sv
module rxc_packer
  import rxc_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim_i,
  input  logic          data_i,
  input  half_t         hw_i,
  input  logic [AW-1:0] base_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output word_t         wdata_o,
  output logic          done_o,
  output logic [AW-1:0] done_addr_o,
  output logic          ev_last_o
);
  localparam int PW = AW + 1;

  half_t          cnt_q;
  logic [PW-1:0]  ptr_q;
  half_t          held_q;
  logic [AW-1:0]  base_q;
  logic           odd;
  logic           last;

  function automatic logic [PW-1:0] first_ptr(input logic [AW-1:0] b);
    return {b + AW'(1), 1'b0};
  endfunction

  assign busy_o = (cnt_q != '0);
  assign odd    = ptr_q[0];
  assign last   = data_i && (cnt_q == half_t'(1));

  always_comb begin
    we_o    = 1'b0;
    addr_o  = ptr_q[PW-1:1];
    wdata_o = '0;
    if (claim_i) begin
      we_o    = 1'b1;
      addr_o  = base_i;
      wdata_o = hdr_word(hw_i);
    end else if (data_i && odd) begin
      we_o    = 1'b1;
      wdata_o = pair_word(held_q, hw_i);
    end else if (last) begin
      we_o    = 1'b1;
      wdata_o = solo_word(hw_i);
    end
  end

  assign done_o      = last;
  assign done_addr_o = base_q;
  assign ev_last_o   = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      held_q <= '0;
      base_q <= '0;
    end else if (claim_i) begin
      cnt_q  <= hw_i;
      ptr_q  <= first_ptr(base_i);
      base_q <= base_i;
    end else if (data_i) begin
      cnt_q <= cnt_q - half_t'(1);
      ptr_q <= ptr_q + PW'(1);
      if (!odd) held_q <= hw_i;
    end
  end
endmodule

// File: rtl/rxc_top.sv
module rxc_top
  import rxc_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake_i,
  input  logic          pend_i,
  input  logic [15:0]   hw_i,
  output logic          acc_o,
  output logic          en_o,
  input  logic          fq_valid_i,
  input  logic [AW-1:0] fq_addr_i,
  input  logic [15:0]   fq_cap_i,
  output logic          fq_pop_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [35:0]   mem_wdata_o,
  output logic          dq_push_o,
  output logic [AW-1:0] dq_addr_o
);
  logic busy;
  logic ev_zero, ev_stall, ev_big, ev_claim, ev_data, ev_last;

  rxc_enable u_en (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .stop_i(ev_stall), .en_o(en_o)
  );

  rxc_frame_ctl u_ctl (
    .busy_i(busy), .en_i(en_o), .pend_i(pend_i), .len_i(hw_i),
    .fq_valid_i(fq_valid_i), .fq_cap_i(fq_cap_i),
    .ev_zero_o(ev_zero), .ev_stall_o(ev_stall), .ev_big_o(ev_big),
    .ev_claim_o(ev_claim), .ev_data_o(ev_data), .acc_o(acc_o)
  );

  rxc_packer #(.AW(AW)) u_pk (
    .clk(clk), .rst_n(rst_n), .claim_i(ev_claim), .data_i(ev_data),
    .hw_i(hw_i), .base_i(fq_addr_i), .busy_o(busy),
    .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .done_o(dq_push_o), .done_addr_o(dq_addr_o), .ev_last_o(ev_last)
  );

  assign fq_pop_o = ev_claim;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          en_o,
  input logic          pend_i,
  input logic [15:0]   hw_i,
  input logic          acc_o,
  input logic          fq_pop_o,
  input logic          mem_we_o,
  input logic [35:0]   mem_wdata_o,
  input logic          dq_push_o,
  input logic          ev_stall,
  input logic          ev_big
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en_o && pend_i) |-> (!acc_o && !fq_pop_o && !mem_we_o));
  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_o && pend_i && hw_i == 16'd0) |-> (acc_o && !fq_pop_o && !mem_we_o));
  // R3
  stall_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> (!en_o && !busy));
  // R4
  oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_big |=> !busy);
  // R5
  claim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_pop_o |=> busy);
  // R6
  accept_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> pend_i);
  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_wdata_o[3:0] == 4'd0));
  // R8
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push_o |-> (mem_we_o && acc_o));
endmodule

bind rxc_top rxc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .en_o(en_o), .pend_i(pend_i),
  .hw_i(hw_i), .acc_o(acc_o), .fq_pop_o(fq_pop_o), .mem_we_o(mem_we_o),
  .mem_wdata_o(mem_wdata_o), .dq_push_o(dq_push_o),
  .ev_stall(ev_stall), .ev_big(ev_big)
);

// File: tb/rxc_top_tb_top.sv
module rxc_top_tb_top;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0, pend = 1'b0, fqv = 1'b0;
  logic [15:0] hw = '0, fcap = '0;
  logic [AW-1:0] faddr = '0;
  logic acc, en, pop, we, push;
  logic [AW-1:0] maddr, daddr;
  logic [35:0] wdata;

  always #2.5 clk = ~clk;

  rxc_top #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .pend_i(pend), .hw_i(hw),
    .acc_o(acc), .en_o(en), .fq_valid_i(fqv), .fq_addr_i(faddr),
    .fq_cap_i(fcap), .fq_pop_o(pop), .mem_we_o(we), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .dq_push_o(push), .dq_addr_o(daddr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [35:0] mem [0:255];
  logic [AW-1:0] q_addr [0:15];
  logic [15:0] q_cap [0:15];
  int qh = 0, qt = 0;
  int done_n = 0;
  logic [AW-1:0] done_last = '0;
  logic s_acc, s_we, s_pop, s_push;
  logic [15:0] pk [0:15];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_hdr(input logic [15:0] len);
    return {2'b00, len, 18'd0};
  endfunction

  function automatic logic [35:0] exp_data(input int k, input int len);
    logic [15:0] lo;
    lo = (2*k + 1 < len) ? pk[2*k+1] : 16'd0;
    return {pk[2*k], lo, 4'd0};
  endfunction

  task automatic step(input logic p, input logic [15:0] d);
    @(negedge clk);
    pend = p; hw = d;
    fqv = (qh < qt);
    faddr = fqv ? q_addr[qh] : '0;
    fcap = fqv ? q_cap[qh] : '0;
    #1;
    s_acc = acc; s_we = we; s_pop = pop; s_push = push;
    if (we) mem[maddr[7:0]] = wdata;
    if (push) begin done_n++; done_last = daddr; end
    if (pop) qh++;
    @(posedge clk); #1;
    if (s_acc) pend = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(posedge clk); #1; wake = 1'b0;
  endtask

  task automatic qpush(input logic [AW-1:0] a, input logic [15:0] c);
    q_addr[qt] = a; q_cap[qt] = c; qt++;
  endtask

  task automatic run_packet(input logic [AW-1:0] base, input int len, input string tag);
    int d0;
    for (int i = 0; i < 8; i++) mem[8'(base) + 8'(i)] = '0;
    d0 = done_n;
    step(1'b1, 16'(len));
    chk(s_acc && s_pop && s_we, {tag, " R5 claim"}, {s_acc, s_pop, s_we}, 3'b111);
    chk(mem[8'(base)] == exp_hdr(16'(len)), {tag, " R5 header"}, mem[8'(base)], exp_hdr(16'(len)));
    for (int i = 0; i < len; i++) begin
      step(1'b1, pk[i]);
      chk(s_acc, {tag, " R6 data accept"}, s_acc, 1);
      chk(s_push == (i == len - 1), {tag, " R8 push timing"}, s_push, (i == len - 1));
    end
    chk(done_n == d0 + 1 && done_last == base, {tag, " R8 done addr"}, done_last, base);
    for (int k = 0; k < (len + 1) / 2; k++)
      chk(mem[8'(base) + 8'(k) + 8'd1] == exp_data(k, len), {tag, " R7 word"},
          mem[8'(base) + 8'(k) + 8'd1], exp_data(k, len));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cap, len;
    logic [AW-1:0] base;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!acc && !en && !we && !pop && !push, "R9 reset state", {acc, en, we, pop, push}, 0);

    // R1: disabled idle ignores pending halfword
    qpush(18'd16, 16'd8);
    step(1'b1, 16'd3);
    chk(!s_acc && !s_pop && !s_we, "R1 disabled idle", {s_acc, s_pop, s_we}, 0);
    step(1'b1, 16'd3);
    chk(!s_acc && qh == 0, "R1 still pending", s_acc, 0);
    pend = 1'b0;

    pulse_wake();
    chk(en, "R9 wake sets enable", en, 1);

    // R2: zero length
    step(1'b1, 16'd0);
    chk(s_acc && !s_pop && !s_we, "R2 zero length", {s_acc, s_pop, s_we}, 3'b100);
    chk(qh == 0, "R2 no pop", qh, 0);

    // R4: oversize then exact fit
    step(1'b1, 16'd9);
    chk(s_acc && !s_pop && !s_we, "R4 oversize drop", {s_acc, s_pop, s_we}, 3'b100);
    for (int i = 0; i < 8; i++) pk[i] = 16'hA000 + 16'(i);
    run_packet(18'd16, 8, "exact-fit");

    // R3: empty queue stops channel
    step(1'b1, 16'd2);
    chk(!s_acc && !s_pop, "R3 stall no accept", s_acc, 0);
    chk(!en, "R3 enable cleared", en, 0);
    step(1'b1, 16'd2);
    chk(!s_acc, "R3 stays pending", s_acc, 0);
    pend = 1'b0;
    pulse_wake();
    chk(en, "R9 re-wake", en, 1);

    // R7/R8 odd length directed
    qpush(18'd32, 16'd3);
    pk[0] = 16'h1111; pk[1] = 16'h2222; pk[2] = 16'hFFFF;
    run_packet(18'd32, 3, "odd3");
    qpush(18'd40, 16'd1);
    pk[0] = 16'hBEEF;
    run_packet(18'd40, 1, "len1");

    // random packets with occasional oversize length first
    for (int p = 0; p < 8; p++) begin
      base = 18'(48 + 16 * p);
      cap = 1 + int'($urandom % 10);
      len = 1 + int'($urandom % cap);
      for (int i = 0; i < len; i++) pk[i] = 16'($urandom);
      qpush(base, 16'(cap));
      if (p % 2 == 1) begin
        step(1'b1, 16'(cap + 1 + int'($urandom % 3)));
        chk(s_acc && !s_pop && !s_we && qh == qt - 1, "R4 random oversize",
            {s_acc, s_pop, s_we}, 3'b100);
      end
      run_packet(base, len, "random");
      step(1'b0, 16'd0);
      chk(!s_acc && !s_we, "R6 idle after packet", {s_acc, s_we}, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule